// File: doc/BRIEF.md
# Multiplexed-Bus Register Interface with Interrupt

This block is the register side of a peripheral on an 8-bit multiplexed address/data bus. The host first pulses an address strobe, and the block captures a 3-bit register address and the chip-select at the falling edge of that strobe. After that, separate active-low read and write strobes move data into or out of the selected register. The registers are two control registers, a tone register and a read-only detect register. All strobes and the chip-select are asynchronous to the system clock. They are synchronized, and their edges are detected in the clock domain.

Detect events arrive as one-cycle pulses. Each pulse sets a sticky flag and pulls an open-drain interrupt low. The interrupt is modelled as an active-low output enable. When the host finishes reading the detect register, the flags clear and the pin is released.

The block also steers the output clock pin. The pin carries the crystal clock unless two bits are both set: the DPSK mode bit and the baud-clock select bit. In that case the pin carries the 16x data-rate clock. An active-high device reset returns every register and the clock choice to their idle state.

Top module: `mbus_regif`

## Requirements
- R1: The register address (bus bits 2:0) and the chip-select level are captured at the falling edge of `ale`. Later changes on the bus or on `cs_n` do not alter the target of the following read or write.
- R2: When the captured chip-select is high (inactive), no register is written and the bus is never driven.
- R3: `ad_oe` is high only while `rd_n` is low and the captured chip-select is low. While it is high, `ad_o` carries the selected register.
- R4: On the rising edge of `wr_n`, the bus byte is written into the register at the captured address. The detect register (address 2) ignores writes.
- R5: A pulse on any bit of `det_evt` sets the matching bit of the detect register. It also drives `irq_oe_n` low, and the pin stays low as long as any flag is set.
- R6: When a read of address 2 completes (rising edge of `rd_n`), all detect flags clear and `irq_oe_n` returns high. An event in that same cycle stays set.
- R7: `clk_out` follows `baud16_clk` only when bit 0 of the control register at address 0 (DPSK mode) and bit 0 of the control register at address 1 (baud-clock select) are both 1. Otherwise it follows `xtal_clk`.
- R8: While `dev_rst` is high, the control registers, the tone register and the detect flags are cleared, the interrupt is released, `clk_out` follows `xtal_clk`, and the bus is not driven.
- R9: Reads of addresses 4 to 7 return 0x00.
- R10: Register map: control A at address 0, control B at address 1, detect at address 2, tone at address 3. Addresses 0, 1 and 3 read back what was written.
- R11: Each strobe edge takes effect within 5 system clock cycles of the pin edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| dev_rst | input | 1 | Active-high device reset pin (asynchronous) |
| ale | input | 1 | Address strobe; capture on falling edge |
| cs_n | input | 1 | Active-low chip-select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_i | input | 8 | Bus value seen at the pads |
| ad_o | output | 8 | Bus value driven by the block |
| ad_oe | output | 1 | Bus output enable |
| det_evt | input | 8 | Detect event pulses, clock domain |
| irq_oe_n | output | 1 | Active-low enable of the open-drain interrupt driver |
| xtal_clk | input | 1 | Crystal clock |
| baud16_clk | input | 1 | Clock at 16x the data rate |
| clk_out | output | 1 | Selected output clock |
| ctrl_a_o | output | 8 | Control register A contents |
| ctrl_b_o | output | 8 | Control register B contents |
| tone_o | output | 8 | Tone register contents |

## Verification
Some rules are checked by assertions on every cycle: the control and tone registers change only on a qualified write or a device clear, and a write to the tone register lands the byte. The interrupt falls after any event, holds until it is cleared, and rises after a detect read that has no competing event. A device clear empties the registers. The bench scenarios cover what depends on the order of strobe edges. These are: capture at the falling edge of the address strobe, despite later bus and chip-select changes; refused writes and reads with chip-select inactive; the read-only detect address; zero reads of unused addresses; the two-bit clock steering condition; and the recovery after a device reset.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL_A = 3'd0,
    RA_CTRL_B = 3'd1,
    RA_DETECT = 3'd2,
    RA_TONE   = 3'd3
  } reg_addr_e;

  localparam int unsigned DPSK_BIT   = 0;
  localparam int unsigned CLKSEL_BIT = 0;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign level_o = stage_q[STAGES-1];
endmodule

// File: rtl/mbus_regbank.sv
module mbus_regbank
  import mbus_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_clr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] det_flags_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_a_o,
  output logic [DATA_W-1:0] ctrl_b_o,
  output logic [DATA_W-1:0] tone_o
);
  logic [DATA_W-1:0] ctrl_a_q, ctrl_b_q, tone_q;
  logic [DATA_W-1:0] ctrl_a_d, ctrl_b_d, tone_d;

  always_comb begin
    ctrl_a_d = ctrl_a_q;
    ctrl_b_d = ctrl_b_q;
    tone_d   = tone_q;
    if (dev_clr_i) begin
      ctrl_a_d = '0;
      ctrl_b_d = '0;
      tone_d   = '0;
    end else if (wr_en_i) begin
      case (addr_i)
        RA_CTRL_A: ctrl_a_d = wdata_i;
        RA_CTRL_B: ctrl_b_d = wdata_i;
        RA_TONE:   tone_d   = wdata_i;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
      tone_q   <= '0;
    end else begin
      ctrl_a_q <= ctrl_a_d;
      ctrl_b_q <= ctrl_b_d;
      tone_q   <= tone_d;
    end
  end

  always_comb begin
    case (addr_i)
      RA_CTRL_A: rdata_o = ctrl_a_q;
      RA_CTRL_B: rdata_o = ctrl_b_q;
      RA_DETECT: rdata_o = det_flags_i;
      RA_TONE:   rdata_o = tone_q;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_a_o = ctrl_a_q;
  assign ctrl_b_o = ctrl_b_q;
  assign tone_o   = tone_q;

  // R4: without a write or clear, register contents hold
  p_regs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !dev_clr_i) |=> ($stable(ctrl_a_q) && $stable(ctrl_b_q) && $stable(tone_q)));

  // R4: a write to the tone address lands the byte
  p_tone_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !dev_clr_i && addr_i == RA_TONE) |=> (tone_q == $past(wdata_i)));

  // R8: device clear empties every control register
  p_dev_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_clr_i |=> (ctrl_a_q == '0 && ctrl_b_q == '0 && tone_q == '0));
endmodule

// File: rtl/mbus_detect.sv
module mbus_detect #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_clr_i,
  input  logic              rd_clr_i,
  input  logic [DATA_W-1:0] evt_i,
  output logic [DATA_W-1:0] flags_o,
  output logic              irq_oe_n_o
);
  logic [DATA_W-1:0] flags_q, flags_d;
  logic              irq_oe_n_q, irq_oe_n_d;

  always_comb begin
    if (dev_clr_i)     flags_d = '0;
    else if (rd_clr_i) flags_d = evt_i;
    else               flags_d = flags_q | evt_i;
    irq_oe_n_d = ~(|flags_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q    <= '0;
      irq_oe_n_q <= 1'b1;
    end else begin
      flags_q    <= flags_d;
      irq_oe_n_q <= irq_oe_n_d;
    end
  end

  assign flags_o    = flags_q;
  assign irq_oe_n_o = irq_oe_n_q;

  // R5: any event outside a device clear pulls the interrupt low
  p_evt_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_i) && !dev_clr_i) |=> !irq_oe_n_q);

  // R5: the interrupt holds until a read clear or device clear
  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_oe_n_q && !rd_clr_i && !dev_clr_i) |=> !irq_oe_n_q);

  // R6: a detect read with no competing event releases the pin
  p_rd_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !(|evt_i)) |=> irq_oe_n_q);
endmodule

// File: rtl/mbus_regif.sv
module mbus_regif
  import mbus_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst,
  input  logic              ale,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] det_evt,
  output logic              irq_oe_n,
  input  logic              xtal_clk,
  input  logic              baud16_clk,
  output logic              clk_out,
  output logic [DATA_W-1:0] ctrl_a_o,
  output logic [DATA_W-1:0] ctrl_b_o,
  output logic [DATA_W-1:0] tone_o
);
  localparam int unsigned N_STRB = 5;
  localparam int unsigned I_ALE = 0, I_RD = 1, I_WR = 2, I_CS = 3, I_DEV = 4;
  localparam logic [N_STRB-1:0] STRB_RST = 5'b11110;
  localparam int unsigned N_EDGE = 3;

  logic [N_STRB-1:0] strb_lvl;
  logic [N_EDGE-1:0] edge_prev_q;
  logic [DATA_W-1:0] bus_q [SYNC_STAGES];

  mbus_sync #(.WIDTH(N_STRB), .STAGES(SYNC_STAGES), .RST_VAL(STRB_RST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({dev_rst, cs_n, wr_n, rd_n, ale}),
    .level_o (strb_lvl)
  );

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_bus
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) bus_q[g] <= '0;
          else        bus_q[g] <= ad_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) bus_q[g] <= '0;
          else        bus_q[g] <= bus_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_prev_q <= STRB_RST[N_EDGE-1:0];
    else        edge_prev_q <= strb_lvl[N_EDGE-1:0];
  end

  logic ale_fall, rd_rise, wr_rise, dev_clr, rd_low;
  assign ale_fall = !strb_lvl[I_ALE] &&  edge_prev_q[I_ALE];
  assign rd_rise  =  strb_lvl[I_RD]  && !edge_prev_q[I_RD];
  assign wr_rise  =  strb_lvl[I_WR]  && !edge_prev_q[I_WR];
  assign rd_low   = !strb_lvl[I_RD];
  assign dev_clr  =  strb_lvl[I_DEV];

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              sel_q, sel_d;

  always_comb begin
    addr_d = addr_q;
    sel_d  = sel_q;
    if (dev_clr) begin
      sel_d = 1'b0;
    end else if (ale_fall) begin
      addr_d = bus_q[SYNC_STAGES-1][ADDR_W-1:0];
      sel_d  = !strb_lvl[I_CS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      sel_q  <= sel_d;
    end
  end

  logic wr_en, rd_active, rd_clr;
  assign wr_en     = wr_rise && sel_q && !dev_clr;
  assign rd_active = rd_low  && sel_q && !dev_clr;
  assign rd_clr    = rd_rise && sel_q && !dev_clr && (addr_q == RA_DETECT);

  logic [DATA_W-1:0] det_flags, rdata;

  mbus_detect #(.DATA_W(DATA_W)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_clr_i  (dev_clr),
    .rd_clr_i   (rd_clr),
    .evt_i      (det_evt),
    .flags_o    (det_flags),
    .irq_oe_n_o (irq_oe_n)
  );

  mbus_regbank #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_clr_i   (dev_clr),
    .wr_en_i     (wr_en),
    .addr_i      (addr_q),
    .wdata_i     (bus_q[SYNC_STAGES-1]),
    .det_flags_i (det_flags),
    .rdata_o     (rdata),
    .ctrl_a_o    (ctrl_a_o),
    .ctrl_b_o    (ctrl_b_o),
    .tone_o      (tone_o)
  );

  assign ad_oe = rd_active;
  assign ad_o  = rd_active ? rdata : '0;

  logic use_baud;
  assign use_baud = ctrl_a_o[DPSK_BIT] && ctrl_b_o[CLKSEL_BIT];
  assign clk_out  = use_baud ? baud16_clk : xtal_clk;

  // R2: an unselected write strobe leaves the control outputs untouched
  p_no_write_unsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !sel_q && !dev_clr) |=> ($stable(ctrl_a_o) && $stable(ctrl_b_o) && $stable(tone_o)));
endmodule

// File: tb/mbus_regif_tb.sv
`timescale 1ns/1ps
module mbus_regif_tb;
  logic clk = 1'b0;
  logic rst_n, dev_rst, ale, cs_n, rd_n, wr_n, xtal_clk, baud16_clk;
  logic [7:0] ad_i, det_evt;
  logic [7:0] ad_o, ctrl_a_o, ctrl_b_o, tone_o;
  logic ad_oe, irq_oe_n, clk_out;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mbus_regif u_dut (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .ale(ale), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .det_evt(det_evt), .irq_oe_n(irq_oe_n), .xtal_clk(xtal_clk),
    .baud16_clk(baud16_clk), .clk_out(clk_out), .ctrl_a_o(ctrl_a_o),
    .ctrl_b_o(ctrl_b_o), .tone_o(tone_o)
  );

  // {rd, cs_n, addr[2:0], wdata[7:0], exp_oe, exp[7:0]}
  localparam int NV = 15;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 8'h5A, 1'b0, 8'h00},
    {1'b0, 1'b0, 3'd1, 8'hC3, 1'b0, 8'h00},
    {1'b0, 1'b0, 3'd3, 8'h7E, 1'b0, 8'h00},
    {1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 8'h5A},
    {1'b1, 1'b0, 3'd1, 8'h00, 1'b1, 8'hC3},
    {1'b1, 1'b0, 3'd3, 8'h00, 1'b1, 8'h7E},
    {1'b0, 1'b1, 3'd0, 8'hFF, 1'b0, 8'h00},
    {1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 8'h5A},
    {1'b0, 1'b0, 3'd2, 8'h11, 1'b0, 8'h00},
    {1'b1, 1'b0, 3'd2, 8'h00, 1'b1, 8'h00},
    {1'b1, 1'b0, 3'd5, 8'h00, 1'b1, 8'h00},
    {1'b1, 1'b0, 3'd7, 8'h00, 1'b1, 8'h00},
    {1'b1, 1'b1, 3'd0, 8'h00, 1'b0, 8'h00},
    {1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00},
    {1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 8'h00}
  };
  localparam string TAG [NV] = '{
    "R4", "R4", "R4", "R10", "R10", "R10", "R2", "R2",
    "R4", "R4", "R9", "R9", "R3", "R3", "R11"
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch(input logic [2:0] a, input logic c);
    @(negedge clk);
    ad_i = {5'b10110, a};
    cs_n = c;
    ale  = 1'b1;
    cyc(5);
    ale = 1'b0;
    cyc(5);
    ad_i = 8'hE6;
    cs_n = ~c;
    cyc(1);
  endtask

  task automatic bwrite(input logic [7:0] d);
    ad_i = d;
    wr_n = 1'b0;
    cyc(5);
    wr_n = 1'b1;
    cyc(5);
    ad_i = 8'h00;
  endtask

  task automatic bread(output logic oe, output logic [7:0] d);
    rd_n = 1'b0;
    cyc(5);
    oe = ad_oe;
    d  = ad_o;
    rd_n = 1'b1;
    cyc(5);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    latch(a, 1'b0);
    bwrite(d);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic oe;
    logic [7:0] d;
    rst_n = 1'b0; dev_rst = 1'b0; ale = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    ad_i = 8'h00; det_evt = 8'h00; xtal_clk = 1'b1; baud16_clk = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);

    // reset state
    chk("R8 reset irq", irq_oe_n, 1'b1);
    chk("R3 reset oe", ad_oe, 1'b0);
    chk("R7 reset clk", clk_out, 1'b1);

    for (int i = 0; i < NV; i++) begin
      latch(VEC[i][19:17], VEC[i][20]);
      if (VEC[i][21]) begin
        bread(oe, d);
        chk({TAG[i], " oe"}, oe, VEC[i][8]);
        if (VEC[i][8]) chk({TAG[i], " data"}, d, VEC[i][7:0]);
      end else begin
        bwrite(VEC[i][16:9]);
      end
    end

    // R1: address/cs captured at ale fall despite later bus and cs changes
    latch(3'd3, 1'b0);
    bwrite(8'h9C);
    latch(3'd3, 1'b0);
    bread(oe, d);
    chk("R1 tone after moved bus", d, 8'h9C);
    chk("R1 tone port", tone_o, 8'h9C);

    // R7: clock steering
    wr_reg(3'd1, 8'h01);
    wr_reg(3'd0, 8'h00);
    chk("R7 select only", clk_out, 1'b1);
    wr_reg(3'd0, 8'h01);
    chk("R7 dpsk and select", clk_out, 1'b0);
    baud16_clk = 1'b1;
    #0.1;
    chk("R7 follows baud", clk_out, 1'b1);
    baud16_clk = 1'b0;
    wr_reg(3'd1, 8'h00);
    chk("R7 dpsk only", clk_out, 1'b1);

    // R5 / R6: detect flags and interrupt
    @(negedge clk);
    det_evt = 8'h04;
    @(negedge clk);
    det_evt = 8'h00;
    cyc(1);
    chk("R5 irq low", irq_oe_n, 1'b0);
    cyc(10);
    chk("R5 irq holds", irq_oe_n, 1'b0);
    @(negedge clk);
    det_evt = 8'h40;
    @(negedge clk);
    det_evt = 8'h00;
    latch(3'd2, 1'b0);
    bread(oe, d);
    chk("R5 detect value", d, 8'h44);
    chk("R6 irq released", irq_oe_n, 1'b1);
    latch(3'd2, 1'b0);
    bread(oe, d);
    chk("R6 flags cleared", d, 8'h00);

    // R8: device reset
    wr_reg(3'd0, 8'h01);
    wr_reg(3'd1, 8'h01);
    wr_reg(3'd3, 8'h33);
    @(negedge clk);
    det_evt = 8'h01;
    @(negedge clk);
    det_evt = 8'h00;
    latch(3'd0, 1'b0);
    chk("R7 baud before reset", clk_out, 1'b0);
    dev_rst = 1'b1;
    cyc(6);
    rd_n = 1'b0;
    cyc(5);
    chk("R8 no drive in reset", ad_oe, 1'b0);
    chk("R8 clk xtal", clk_out, 1'b1);
    chk("R8 irq released", irq_oe_n, 1'b1);
    rd_n = 1'b1;
    cyc(5);
    dev_rst = 1'b0;
    cyc(6);
    latch(3'd0, 1'b0);
    bread(oe, d);
    chk("R8 ctrl a cleared", d, 8'h00);
    latch(3'd1, 1'b0);
    bread(oe, d);
    chk("R8 ctrl b cleared", d, 8'h00);
    latch(3'd3, 1'b0);
    bread(oe, d);
    chk("R8 tone cleared", d, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule